// File: doc/BRIEF.md
# I2C Master Receive Holding Buffer with Clock Stretch

This block sits between the bit-level receive shifter of an I2C master and the software-visible data register. Each byte the shifter completes is offered with a one-cycle strobe. The block stores it in a holding store that is either one or two bytes deep, and raises a data-ready flag. When the store cannot take another byte, the block pulls SCL low so that the bus waits. Software chooses the depth at run time with a mode bit. It reads bytes oldest first and can clear the flag with a separate strobe. Clearing the flag always lets SCL go.

A bypass bit hands both bus lines to two register bits, so software can drive SCL and SDA directly for bus recovery. Two read-back outputs report the sampled SCL pin level and the bus-busy status. These replace the register bits that were written. Both lines use open-drain encoding: an output of 0 enables the pull-down and 1 releases the line.

Top module: `i2c_rx_stretch_buf`

## Requirements
- R1: While reset is asserted and in the first cycle after it, data_ready is 0, rd_data is 0, and scl_o and sda_o are both 1 (released).
- R2: Accepted bytes are presented on rd_data oldest first. rd_data is 0 when the store is empty. A rd_strobe removes the oldest byte. A byte offered while the store is at capacity is dropped, unless a read in the same cycle frees a place.
- R3: With single_mode = 0 (two-byte store), outside bypass, scl_o is 0 exactly when two bytes are held and data_ready is 1.
- R4: With single_mode = 1 (one-byte store), outside bypass, scl_o is 0 from the cycle after a byte is captured until data_ready is cleared.
- R5: A flag_clr strobe sets data_ready to 0 in the next cycle and so releases SCL in either mode. A capture in the same cycle takes priority and leaves the flag set.
- R6: A capture sets data_ready. A read that leaves the store empty clears it. A read that leaves a byte pending keeps it set.
- R7: With bypass_en = 1, scl_o follows force_scl and sda_o follows force_sda. With bypass_en = 0, the force bits have no effect, sda_o is 1, and scl_o follows the stretch rule.
- R8: scl_rd always equals the sampled SCL pin scl_in. sda_rd always equals bus_busy (1 = busy).
- R9: A rd_strobe while the store is empty changes neither rd_data nor data_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_data |
| rx_data | input | DW | Received byte |
| rd_strobe | input | 1 | Software read of the data register (removes the oldest byte) |
| flag_clr | input | 1 | Software clear of the data-ready flag |
| single_mode | input | 1 | Buffer select: 0 two-byte store, 1 one-byte store |
| bypass_en | input | 1 | Hands the bus lines to force_scl and force_sda |
| force_scl | input | 1 | Written forced-SCL bit |
| force_sda | input | 1 | Written forced-SDA bit |
| scl_in | input | 1 | Sampled SCL pin level |
| bus_busy | input | 1 | Bus-busy status from the bus monitor |
| rd_data | output | DW | Oldest held byte, 0 when empty |
| data_ready | output | 1 | Data-ready flag |
| scl_o | output | 1 | SCL open-drain control, 0 pulls low |
| sda_o | output | 1 | SDA open-drain control, 0 pulls low |
| scl_rd | output | 1 | Read-back of the SCL pin level |
| sda_rd | output | 1 | Read-back of bus-busy status |

## Verification
The bench targets the cycle where a read and a new byte meet at a full store. A design that checks capacity before the pop would drop that byte, and one that writes the wrong slot would reorder the data. It clears the flag without reading, then offers more bytes. A design that ties the stretch to occupancy alone would keep SCL low after the clear, and one that lets the clear win over a capture would lose the flag. It also switches the depth while two bytes are held, toggles the force bits with bypass off, and reads an empty store. These cases expose a design that sizes its stretch test by the old mode, leaks the force bits onto the bus, or disturbs the flag on an empty read.

// File: rtl/i2c_rx_stretch_buf.sv
module i2c_rx_stretch_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rd_strobe,
  input  logic          flag_clr,
  input  logic          single_mode,
  input  logic          bypass_en,
  input  logic          force_scl,
  input  logic          force_sda,
  input  logic          scl_in,
  input  logic          bus_busy,
  output logic [DW-1:0] rd_data,
  output logic          data_ready,
  output logic          scl_o,
  output logic          sda_o,
  output logic          scl_rd,
  output logic          sda_rd
);

  logic [DW-1:0] slot0, slot1;
  logic [1:0]    cnt;
  logic          flag;

  logic [1:0] cap;
  logic       pop, push, hold;
  logic [1:0] cnt_left;

  assign cap      = single_mode ? 2'd1 : 2'd2;
  assign pop      = rd_strobe && (cnt != 2'd0);
  assign cnt_left = cnt - {1'b0, pop};
  assign push     = rx_valid && ((cnt < cap) || pop);
  assign hold     = flag && (cnt >= cap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot0 <= '0;
      slot1 <= '0;
      cnt   <= 2'd0;
      flag  <= 1'b0;
    end else begin
      if (pop) slot0 <= slot1;
      if (push) begin
        if (cnt_left == 2'd0) slot0 <= rx_data;
        else                  slot1 <= rx_data;
      end
      cnt <= cnt_left + {1'b0, push};
      if (push)                           flag <= 1'b1;
      else if (flag_clr)                  flag <= 1'b0;
      else if (pop && cnt_left == 2'd0)   flag <= 1'b0;
    end
  end

  assign rd_data    = (cnt != 2'd0) ? slot0 : '0;
  assign data_ready = flag;
  assign scl_o      = bypass_en ? force_scl : !hold;
  assign sda_o      = bypass_en ? force_sda : 1'b1;
  assign scl_rd     = scl_in;
  assign sda_rd     = bus_busy;

endmodule

module i2c_rx_stretch_buf_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rd_strobe,
  input logic          flag_clr,
  input logic          bypass_en,
  input logic          scl_o,
  input logic          sda_o,
  input logic          data_ready,
  input logic [DW-1:0] rd_data,
  input logic [1:0]    cnt,
  input logic [1:0]    cap
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!data_ready && scl_o && sda_o));

  p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd2 && !rd_strobe) |=> (cnt == 2'd2 && $stable(rd_data)));

  p_stretch_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_en && !scl_o) |-> data_ready);

  p_clear_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !rx_valid) |=> !data_ready);

  p_capture_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cnt < cap) |=> data_ready);

  p_last_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && cnt == 2'd1 && !rx_valid) |=> !data_ready);

  p_sda_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_en |-> sda_o);

endmodule

bind i2c_rx_stretch_buf i2c_rx_stretch_buf_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rd_strobe(rd_strobe),
  .flag_clr(flag_clr), .bypass_en(bypass_en), .scl_o(scl_o), .sda_o(sda_o),
  .data_ready(data_ready), .rd_data(rd_data), .cnt(cnt), .cap(cap)
);

// File: tb/i2c_rx_stretch_buf_tb.sv
module i2c_rx_stretch_buf_tb;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n, rx_valid, rd_strobe, flag_clr, single_mode, bypass_en;
  logic force_scl, force_sda, scl_in, bus_busy;
  logic [DW-1:0] rx_data;
  logic [DW-1:0] rd_data;
  logic data_ready, scl_o, sda_o, scl_rd, sda_rd;

  int checks = 0;
  int errors = 0;
  int q[$];
  bit m_flag = 0;

  always #4 clk = ~clk;

  i2c_rx_stretch_buf #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rd_strobe(rd_strobe), .flag_clr(flag_clr), .single_mode(single_mode),
    .bypass_en(bypass_en), .force_scl(force_scl), .force_sda(force_sda),
    .scl_in(scl_in), .bus_busy(bus_busy), .rd_data(rd_data),
    .data_ready(data_ready), .scl_o(scl_o), .sda_o(sda_o),
    .scl_rd(scl_rd), .sda_rd(sda_rd)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_update();
    int cap = single_mode ? 1 : 2;
    bit pop = rd_strobe && q.size() > 0;
    bit acc = rx_valid && (q.size() < cap || pop);
    if (pop) void'(q.pop_front());
    if (acc) q.push_back(int'(rx_data));
    if (acc) m_flag = 1;
    else if (flag_clr) m_flag = 0;
    else if (pop && q.size() == 0) m_flag = 0;
  endtask

  task automatic compare_all();
    int cap = single_mode ? 1 : 2;
    int exp_data = q.size() > 0 ? q[0] : 0;
    int exp_scl = bypass_en ? int'(force_scl) : ((m_flag && q.size() >= cap) ? 0 : 1);
    chk("R2", "rd_data", int'(rd_data), exp_data);
    chk("R6", "data_ready", int'(data_ready), int'(m_flag));
    chk(bypass_en ? "R7" : (single_mode ? "R4" : "R3"), "scl_o", int'(scl_o), exp_scl);
    chk("R7", "sda_o", int'(sda_o), bypass_en ? int'(force_sda) : 1);
    chk("R8", "scl_rd", int'(scl_rd), int'(scl_in));
    chk("R8", "sda_rd", int'(sda_rd), int'(bus_busy));
  endtask

  task automatic step(bit rx, logic [DW-1:0] d, bit rd, bit clr);
    rx_valid = rx; rx_data = d; rd_strobe = rd; flag_clr = clr;
    @(posedge clk);
    model_update();
    @(negedge clk);
    rx_valid = 0; rd_strobe = 0; flag_clr = 0;
    compare_all();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; rx_valid = 0; rx_data = 0; rd_strobe = 0; flag_clr = 0;
    single_mode = 0; bypass_en = 0; force_scl = 0; force_sda = 0;
    scl_in = 1; bus_busy = 0;
    repeat (3) @(negedge clk);
    chk("R1", "data_ready in reset", int'(data_ready), 0);
    chk("R1", "scl_o in reset", int'(scl_o), 1);
    chk("R1", "sda_o in reset", int'(sda_o), 1);
    chk("R1", "rd_data in reset", int'(rd_data), 0);
    rst_n = 1;
    @(negedge clk);
    compare_all();

    // two-byte store: fill, overflow, clear, drain (R2, R3, R5)
    step(1, 8'hA1, 0, 0);
    chk("R3", "one byte held, no stretch", int'(scl_o), 1);
    step(1, 8'hB2, 0, 0);
    chk("R3", "two bytes held, stretch", int'(scl_o), 0);
    step(1, 8'hC3, 0, 0);
    chk("R2", "overflow byte dropped, head kept", int'(rd_data), 8'hA1);
    step(0, 0, 0, 1);
    chk("R5", "clear releases scl", int'(scl_o), 1);
    chk("R5", "clear drops flag", int'(data_ready), 0);
    step(0, 0, 1, 0);
    chk("R2", "second byte after read", int'(rd_data), 8'hB2);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    chk("R9", "empty read keeps flag low", int'(data_ready), 0);
    chk("R9", "empty read keeps data 0", int'(rd_data), 0);

    // capture beats clear in same cycle (R5)
    step(1, 8'h11, 0, 1);
    chk("R5", "capture wins over clear", int'(data_ready), 1);
    step(1, 8'h22, 0, 0);
    step(1, 8'h33, 1, 0);
    chk("R2", "read+write at full keeps order", int'(rd_data), 8'h22);
    step(0, 0, 1, 0);
    chk("R6", "pending byte keeps flag", int'(data_ready), 1);
    step(0, 0, 1, 0);
    chk("R6", "last read clears flag", int'(data_ready), 0);

    // one-byte store (R4)
    single_mode = 1;
    step(1, 8'h5A, 0, 0);
    chk("R4", "single byte captured, stretch", int'(scl_o), 0);
    step(1, 8'h6B, 0, 0);
    chk("R4", "second byte dropped", int'(rd_data), 8'h5A);
    step(0, 0, 0, 1);
    chk("R4", "clear ends stretch", int'(scl_o), 1);
    step(0, 0, 1, 0);

    // depth switch while two held
    single_mode = 0;
    step(1, 8'h01, 0, 0);
    step(1, 8'h02, 0, 0);
    single_mode = 1;
    @(negedge clk);
    compare_all();
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);

    // bypass and force bits (R7), read-back (R8)
    force_scl = 0; force_sda = 0;
    @(negedge clk);
    chk("R7", "force bits ignored without bypass scl", int'(scl_o), 1);
    chk("R7", "force bits ignored without bypass sda", int'(sda_o), 1);
    bypass_en = 1;
    for (int i = 0; i < 4; i++) begin
      force_scl = i[0]; force_sda = i[1];
      @(negedge clk);
      chk("R7", "bypass scl", int'(scl_o), int'(force_scl));
      chk("R7", "bypass sda", int'(sda_o), int'(force_sda));
    end
    bypass_en = 0;
    scl_in = 0; bus_busy = 1;
    @(negedge clk);
    chk("R8", "scl pin read-back", int'(scl_rd), 0);
    chk("R8", "busy read-back", int'(sda_rd), 1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 31) == 0) single_mode = $urandom_range(0, 1);
      if ($urandom_range(0, 63) == 0) bypass_en = $urandom_range(0, 1);
      force_scl = $urandom_range(0, 1);
      force_sda = $urandom_range(0, 1);
      scl_in = $urandom_range(0, 1);
      bus_busy = $urandom_range(0, 1);
      step($urandom_range(0, 2) == 0, DW'($urandom), $urandom_range(0, 2) == 0,
           $urandom_range(0, 5) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule